// File: doc/BRIEF.md
# Banked Byte Register File with Pointer Indirection

This block is the data register store of a small 8-bit controller core. It holds two banks of byte registers, and one bit of the status register chooses which bank a file address reaches. Reads are combinational from the resolved address. Byte writes and single-bit set or clear operations take effect on the rising clock edge. A single-bit test output gives one bit of the register being read.

File address zero is a window. Any access made through it goes to the address held in the pointer register, and that pointer address is used as a full two-bank address. Six core registers have one copy of storage that both banks see: the window, the PC low byte, status, pointer, the PC high latch and interrupt control. A byte write to the PC low byte, in either bank, also raises a load request for the program-counter unit. The pointer value and the bank-select bit are exposed to the rest of the core.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears every register, so after reset every read returns 0x00, `pointer` is 0x00 and `bank_sel` is 0.
- R2: The effective address is the file address plus 0x80 when bit 5 of the status register (file address 0x03) is 1, and plus 0 otherwise. A write to a register that is not shared reaches only the selected bank.
- R3: File addresses 0x00, 0x02, 0x03, 0x04, 0x0A and 0x0B are shared. A write to any of them in either bank is read back at the same file address in both banks.
- R4: A read, write, bit set, bit clear or bit test at file address 0x00 uses the 8-bit pointer value (file address 0x04) as the full effective address. The bank offset is not added, and the shared-register rule still applies.
- R5: When the pointer holds 0x00 or 0x80, an access through address 0x00 reads 0x00, and a write or bit operation through it changes nothing.
- R6: A bit set or bit clear changes only bit `bit_sel` of the resolved register at the clock edge. `bit_val` equals bit `bit_sel` of the current read data.
- R7: When several operations are requested in one cycle, a byte write wins over a bit set, and a bit set wins over a bit clear.
- R8: `pc_load` is 1, in the same cycle, exactly when `wr_en` is 1 and the file address is 0x02, whichever bank is selected.
- R9: `pointer` shows the contents of register 0x04, and `bank_sel` shows bit 5 of register 0x03. Both follow a write on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| faddr | input | 7 | File address within the selected bank |
| wr_en | input | 1 | Byte write of `wdata` to the resolved register |
| wdata | input | 8 | Byte write data |
| bit_set | input | 1 | Set bit `bit_sel` of the resolved register |
| bit_clr | input | 1 | Clear bit `bit_sel` of the resolved register |
| bit_sel | input | 3 | Bit index for set, clear and test |
| rdata | output | 8 | Combinational read data of the resolved register |
| bit_val | output | 1 | Bit `bit_sel` of `rdata` |
| pointer | output | 8 | Current pointer register value |
| bank_sel | output | 1 | Current bank-select bit |
| pc_load | output | 1 | PC low byte written this cycle |

## Verification
Some properties are checked by assertions on every cycle. These are the zero read through a null pointer, and that a bit operation flips at most one bit. Also checked each cycle: direct writes to the pointer and status registers show up on `pointer` and `bank_sel` one edge later, and storage reads zero right after reset. Bank separation of ordinary registers, mirroring of the shared set, and indirection across banks need a chain of writes and reads, so only the bench scenarios show them. The same holds for discarded null writes, operation priority, and the `pc_load` strobe in both banks.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned ADR_WINDOW = 'h00;
  localparam int unsigned ADR_PCLO   = 'h02;
  localparam int unsigned ADR_STAT   = 'h03;
  localparam int unsigned ADR_PTR    = 'h04;
  localparam int unsigned ADR_PCHI   = 'h0A;
  localparam int unsigned ADR_IRQC   = 'h0B;

  // True for the in-bank offsets that both banks share (one storage copy)
  function automatic logic is_shared(input int unsigned off);
    return (off == ADR_WINDOW) || (off == ADR_PCLO) || (off == ADR_STAT) ||
           (off == ADR_PTR) || (off == ADR_PCHI) || (off == ADR_IRQC);
  endfunction
endpackage

// File: rtl/brf_resolve.sv
module brf_resolve #(
  parameter int FILE_AW = 7,
  parameter int EFF_AW  = FILE_AW + 1
) (
  input  logic [FILE_AW-1:0] faddr,
  input  logic               bank,
  input  logic [EFF_AW-1:0]  ptr,
  output logic [EFF_AW-1:0]  res_addr,
  output logic               via_window,
  output logic               null_ptr
);
  import brf_pkg::*;

  logic [FILE_AW-1:0] low_part;
  logic               high_part;

  always_comb begin
    via_window = (faddr == FILE_AW'(ADR_WINDOW));
    low_part   = via_window ? ptr[FILE_AW-1:0] : faddr;
    high_part  = via_window ? ptr[EFF_AW-1] : bank;
    null_ptr   = via_window && (low_part == FILE_AW'(ADR_WINDOW));
    // shared registers fold onto bank-0 storage
    if (is_shared(int'(low_part))) res_addr = {1'b0, low_part};
    else                           res_addr = {high_part, low_part};
  end
endmodule

// File: rtl/brf_bitop.sv
module brf_bitop #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              bit_set,
  input  logic              bit_clr,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [DATA_W-1:0] next_val,
  output logic              any_op
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask   = DATA_W'(1) << bit_sel;
    any_op = wr_en | bit_set | bit_clr;
    if (wr_en)        next_val = wdata;
    else if (bit_set) next_val = cur | mask;
    else if (bit_clr) next_val = cur & ~mask;
    else              next_val = cur;
  end

  // R6: a bit operation alters at most one bit
  always_comb begin
    if (!wr_en && (bit_set || bit_clr))
      a_r6_single_bit: assert ($countones(next_val ^ cur) <= 1);
  end
endmodule

// File: rtl/brf_store.sv
module brf_store #(
  parameter int EFF_AW    = 8,
  parameter int DATA_W    = 8,
  parameter int PTR_ADR   = 4,
  parameter int STAT_ADR  = 3,
  parameter int DEPTH     = 1 << EFF_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [EFF_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EFF_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ptr_q,
  output logic [DATA_W-1:0] stat_q
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata  = cells[raddr];
  assign ptr_q  = cells[PTR_ADR];
  assign stat_q = cells[STAT_ADR];

  // R1: the edge after reset leaves every cell cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rdata == '0) && (ptr_q == '0) && (stat_q == '0));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W   = 8,
  parameter int FILE_AW  = 7,
  parameter int BANK_BIT = 5,
  parameter int SEL_W    = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FILE_AW-1:0] faddr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               bit_set,
  input  logic               bit_clr,
  input  logic [SEL_W-1:0]   bit_sel,
  output logic [DATA_W-1:0]  rdata,
  output logic               bit_val,
  output logic [DATA_W-1:0]  pointer,
  output logic               bank_sel,
  output logic               pc_load
);
  import brf_pkg::*;

  localparam int EFF_AW = FILE_AW + 1;

  logic [EFF_AW-1:0] res_addr;
  logic              via_window, null_ptr;
  logic [DATA_W-1:0] cell_rd, next_val, stat_q;
  logic              any_op, commit;

  brf_resolve #(.FILE_AW(FILE_AW), .EFF_AW(EFF_AW)) u_resolve (
    .faddr(faddr), .bank(bank_sel), .ptr(pointer[EFF_AW-1:0]),
    .res_addr(res_addr), .via_window(via_window), .null_ptr(null_ptr)
  );

  brf_bitop #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bitop (
    .cur(cell_rd), .wdata(wdata), .wr_en(wr_en), .bit_set(bit_set),
    .bit_clr(bit_clr), .bit_sel(bit_sel), .next_val(next_val), .any_op(any_op)
  );

  assign commit = any_op && !null_ptr;

  brf_store #(.EFF_AW(EFF_AW), .DATA_W(DATA_W),
              .PTR_ADR(ADR_PTR), .STAT_ADR(ADR_STAT)) u_store (
    .clk(clk), .rst(rst), .we(commit), .waddr(res_addr), .wdata(next_val),
    .raddr(res_addr), .rdata(cell_rd), .ptr_q(pointer), .stat_q(stat_q)
  );

  assign bank_sel = stat_q[BANK_BIT];
  assign rdata    = null_ptr ? '0 : cell_rd;
  assign bit_val  = rdata[bit_sel];
  assign pc_load  = wr_en && (faddr == FILE_AW'(ADR_PCLO));

  // R5: null pointer window reads as zero
  a_r5_null_read: assert property (@(posedge clk) disable iff (rst)
    (faddr == '0 && pointer[FILE_AW-1:0] == '0) |-> rdata == '0);

  // R9: direct pointer write appears on the pointer output next edge
  a_r9_ptr_follows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && faddr == FILE_AW'(ADR_PTR)) |=> pointer == $past(wdata));

  // R3: status is shared, so a byte write from either bank sets bank_sel
  a_r3_status_shared: assert property (@(posedge clk) disable iff (rst)
    (wr_en && faddr == FILE_AW'(ADR_STAT)) |=> bank_sel == $past(wdata[BANK_BIT]));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] faddr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       bit_set = 1'b0;
  logic       bit_clr = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] rdata, pointer;
  logic       bit_val, bank_sel, pc_load;

  int checks = 0;
  int errors = 0;
  logic seen_pcl;

  banked_regfile uut (
    .clk(clk), .rst(rst), .faddr(faddr), .wr_en(wr_en), .wdata(wdata),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_sel(bit_sel),
    .rdata(rdata), .bit_val(bit_val), .pointer(pointer),
    .bank_sel(bank_sel), .pc_load(pc_load)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [6:0] a, input logic we, input logic [7:0] d,
                    input logic s, input logic c, input logic [2:0] b);
    @(negedge clk);
    faddr = a; wr_en = we; wdata = d; bit_set = s; bit_clr = c; bit_sel = b;
    #1 seen_pcl = pc_load;
    @(negedge clk);
    wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    op(a, 1'b1, d, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [7:0] exp);
    faddr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic t_reset;
    rd("R1 read after reset", 7'h25, 8'h00);
    chk("R1 pointer after reset", pointer, 8'h00);
    chk("R1 bank_sel after reset", {7'd0, bank_sel}, 8'h00);
    wr(7'h25, 8'hAA);
    rd("R1 pre-reset write", 7'h25, 8'hAA);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd("R1 cleared by reset", 7'h25, 8'h00);
  endtask

  task automatic t_bank;
    wr(7'h20, 8'h11);
    wr(7'h03, 8'h20);
    chk("R9 bank_sel set", {7'd0, bank_sel}, 8'h01);
    rd("R2 bank1 separate", 7'h20, 8'h00);
    wr(7'h20, 8'h22);
    rd("R2 bank1 write", 7'h20, 8'h22);
    wr(7'h03, 8'h00);
    rd("R2 bank0 kept", 7'h20, 8'h11);
  endtask

  task automatic t_shared;
    wr(7'h0A, 8'h5A);
    wr(7'h03, 8'h20);
    rd("R3 pchi seen in bank1", 7'h0A, 8'h5A);
    rd("R3 status seen in bank1", 7'h03, 8'h20);
    wr(7'h0B, 8'h77);
    wr(7'h03, 8'h00);
    rd("R3 irqc seen in bank0", 7'h0B, 8'h77);
  endtask

  task automatic t_indirect;
    wr(7'h04, 8'h30);
    chk("R9 pointer output", pointer, 8'h30);
    wr(7'h00, 8'h99);
    rd("R4 indirect write lands", 7'h30, 8'h99);
    rd("R4 indirect read", 7'h00, 8'h99);
    wr(7'h04, 8'hB0);
    wr(7'h00, 8'h44);
    rd("R4 bank0 cell untouched", 7'h30, 8'h99);
    wr(7'h03, 8'h20);
    rd("R4 full address to bank1", 7'h30, 8'h44);
    wr(7'h04, 8'h30);
    rd("R4 no bank offset on pointer", 7'h00, 8'h99);
    wr(7'h04, 8'h83);
    rd("R4 pointer to shared status", 7'h00, 8'h20);
    wr(7'h03, 8'h00);
  endtask

  task automatic t_null;
    wr(7'h04, 8'h00);
    rd("R5 null read", 7'h00, 8'h00);
    wr(7'h00, 8'h55);
    rd("R5 null write discarded", 7'h00, 8'h00);
    chk("R5 pointer intact", pointer, 8'h00);
    wr(7'h04, 8'h80);
    op(7'h00, 1'b0, 8'h00, 1'b1, 1'b0, 3'd5);
    rd("R5 null bitset read", 7'h00, 8'h00);
    chk("R5 pointer unchanged", pointer, 8'h80);
    chk("R5 bank unchanged", {7'd0, bank_sel}, 8'h00);
  endtask

  task automatic t_bits;
    wr(7'h21, 8'h0F);
    op(7'h21, 1'b0, 8'h00, 1'b1, 1'b0, 3'd7);
    rd("R6 bit set", 7'h21, 8'h8F);
    op(7'h21, 1'b0, 8'h00, 1'b0, 1'b1, 3'd0);
    rd("R6 bit clear", 7'h21, 8'h8E);
    bit_sel = 3'd1; rd("R6 read for test", 7'h21, 8'h8E);
    chk("R6 bit test one", {7'd0, bit_val}, 8'h01);
    bit_sel = 3'd0; #1 chk("R6 bit test zero", {7'd0, bit_val}, 8'h00);
    wr(7'h04, 8'h21);
    op(7'h00, 1'b0, 8'h00, 1'b1, 1'b0, 3'd4);
    rd("R4 indirect bit set", 7'h21, 8'h9E);
    op(7'h03, 1'b0, 8'h00, 1'b1, 1'b0, 3'd5);
    chk("R6 set bank bit", {7'd0, bank_sel}, 8'h01);
    op(7'h03, 1'b0, 8'h00, 1'b0, 1'b1, 3'd5);
    chk("R6 clear bank bit", {7'd0, bank_sel}, 8'h00);
  endtask

  task automatic t_prio;
    wr(7'h22, 8'h10);
    op(7'h22, 1'b1, 8'h00, 1'b1, 1'b0, 3'd3);
    rd("R7 write beats set", 7'h22, 8'h00);
    op(7'h22, 1'b0, 8'h00, 1'b1, 1'b1, 3'd2);
    rd("R7 set beats clear", 7'h22, 8'h04);
  endtask

  task automatic t_pcload;
    wr(7'h02, 8'h12);
    chk("R8 pc_load bank0", {7'd0, seen_pcl}, 8'h01);
    wr(7'h03, 8'h20);
    chk("R8 no pc_load on status", {7'd0, seen_pcl}, 8'h00);
    wr(7'h02, 8'h34);
    chk("R8 pc_load bank1", {7'd0, seen_pcl}, 8'h01);
    op(7'h02, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0);
    chk("R8 no pc_load on bit op", {7'd0, seen_pcl}, 8'h00);
    wr(7'h03, 8'h00);
    rd("R3 pclo shared", 7'h02, 8'h35);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bank();
    t_shared();
    t_indirect();
    t_null();
    t_bits();
    t_prio();
    t_pcload();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule